// File: doc/BRIEF.md
# Smart Card Character Transmitter with Automatic Repetition

This block sends bytes to a smart card over a single half-duplex I/O line using the character-oriented T=0 protocol. A host places a byte in a one-byte holding register. When the transmitter is free it copies that byte into a frame register. It then drives a low start bit, the eight data bits least significant first, and an even parity bit. Each bit lasts a fixed number of clock cycles.

After the parity bit the block releases the line for one bit period and samples it at the middle of that period. If the card pulls the line low there, the character was rejected. The block raises an error flag and, when enabled, an error interrupt. It waits one more bit period and then sends the same character again.

A character that draws no error completes the transfer. The block raises a transmit-end flag and, when enabled, a transmit-end interrupt. A programmable repetition limit stops the block after too many rejections. It then leaves the error flag set and transmit-end clear until the host writes a new byte.

Top module: `sc_t0_tx`

## Requirements
- R1: After reset the line output is high, the data-empty flag `tdre` is 1, the transmit-end flag `tend` is 1, the error flag `ers` is 0, and both interrupt outputs are 0 while their enables are 0.
- R2: A write pulse stores the byte and clears both `tdre` and `tend` on the next clock edge. When the transmitter is idle, the byte is moved into the frame register on the following edge, where `tdre` returns to 1 and the start bit begins.
- R3: A frame puts the following on `ioOut`, each for ETU clock cycles: a low start bit, data bits D0 to D7 in that order, and a parity bit equal to the XOR of the eight data bits (even parity). `ioOut` stays high in the bit period after parity and whenever the block is not sending.
- R4: The line input is sampled ETU/2 cycles into the bit period after parity. If it is low, `ers` is set to 1. A one-cycle `errClr` pulse clears `ers` to 0.
- R5: `errIrq` equals `ers` gated by `rieEn`.
- R6: A frame that drew an error never sets `tend`. The same byte is sent again, with its start bit beginning one ETU after the end of the sampled bit period.
- R7: A frame with no error leaves `ers` at 0. At the end of the sampled bit period it sets `tend` to 1 if no new byte is waiting. `endIrq` equals `tend` gated by `tieEn`.
- R8: `retryLimit` = 0 allows unlimited repetitions. A value N allows at most N repetitions of one byte. An error on the last allowed repetition stops the block: the line stays high, `ers` stays 1 and `tend` stays 0 until a new byte is written.
- R9: A byte written while a frame is in progress is loaded right after that character completes without error. `tend` then stays 0 until the new byte's own frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | One-cycle pulse that writes `wrData` into the holding register |
| wrData | input | 8 | Byte to transmit |
| errClr | input | 1 | One-cycle pulse that clears the error flag |
| rieEn | input | 1 | Error interrupt enable |
| tieEn | input | 1 | Transmit-end interrupt enable |
| retryLimit | input | LIM_W | Maximum repetitions per byte, 0 for unlimited; hold stable while a byte is in flight |
| ioIn | input | 1 | Sampled state of the card I/O line |
| ioOut | output | 1 | Level driven toward the I/O line (1 = released/high) |
| tdre | output | 1 | Holding register empty |
| tend | output | 1 | Character fully transmitted |
| ers | output | 1 | Error signal seen from the card |
| errIrq | output | 1 | Error interrupt request |
| endIrq | output | 1 | Transmit-end interrupt request |

## Verification
A bit counter or bit index that drifts shows on `ioOut` within one frame. The bench decodes every frame at mid-bit, so a wrong bit order, wrong parity or wrong bit length fails on the first character sent. A mistake in the sampling or repetition path shows within about twelve bit periods of the injected error pulse: `ers` stays clear, `tend` rises on a rejected character, or no repeat frame starts. A miscount of repetitions appears only at the limit. There the line must stay quiet and the flags must stay frozen, and the bench checks both for many bit periods.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
  localparam int GUARD_IDX = 10;   // bit slot after parity: line released, card may answer

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_STOP
  } txState_t;

  typedef struct packed {
    logic       load;    // copy holding register into frame register
    logic       sample;  // capture the line for the error signal
    logic       done;    // character finished without error
    logic       active;  // a frame is on the line
    logic [3:0] bitSel;  // which slot of the frame is being driven
  } txCtl_t;
endpackage

// File: rtl/sc_tx_ctrl.sv
module sc_tx_ctrl
  import sc_tx_pkg::*;
#(
  parameter int ETU   = 372,
  parameter int LIM_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             holdFull,
  input  logic             errSeen,
  input  logic [LIM_W-1:0] retryLimit,
  output txCtl_t           ctl
);
  localparam int CNT_W = $clog2(ETU);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(ETU - 1);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(ETU / 2);
  localparam logic [3:0]       GUARD_C = 4'(GUARD_IDX);

  txState_t         state;
  logic [CNT_W-1:0] etuCnt;
  logic [3:0]       bitIdx;
  logic [LIM_W-1:0] retries;
  logic             etuEnd, guardEnd, limitHit;

  always_comb begin
    etuEnd      = (etuCnt == LAST_C);
    guardEnd    = (state == ST_SEND) && (bitIdx == GUARD_C) && etuEnd;
    limitHit    = (retryLimit != '0) && (retries == retryLimit);
    ctl.load    = ((state == ST_IDLE) || (state == ST_STOP)) && holdFull;
    ctl.sample  = (state == ST_SEND) && (bitIdx == GUARD_C) && (etuCnt == HALF_C);
    ctl.done    = guardEnd && !errSeen;
    ctl.active  = (state == ST_SEND);
    ctl.bitSel  = bitIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      etuCnt  <= '0;
      bitIdx  <= '0;
      retries <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_STOP: begin
          if (holdFull) begin
            state   <= ST_SEND;
            etuCnt  <= '0;
            bitIdx  <= '0;
            retries <= '0;
          end
        end
        ST_SEND: begin
          if (etuEnd) begin
            etuCnt <= '0;
            if (bitIdx == GUARD_C) begin
              if (!errSeen) begin
                state <= ST_IDLE;
              end else if (limitHit) begin
                state <= ST_STOP;
              end else begin
                retries <= retries + 1'b1;
                state   <= ST_WAIT;
              end
            end else begin
              bitIdx <= bitIdx + 4'd1;
            end
          end else begin
            etuCnt <= etuCnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (etuEnd) begin
            etuCnt <= '0;
            bitIdx <= '0;
            state  <= ST_SEND;
          end else begin
            etuCnt <= etuCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: counters never leave the frame geometry
  a_r3_count_range: assert property (@(posedge clk) disable iff (!rstN)
    (etuCnt <= LAST_C) && (bitIdx <= GUARD_C));

  // R8: a repetition never exceeds a nonzero limit
  a_r8_retry_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && retryLimit != '0) |-> (retries <= retryLimit));
endmodule

// File: rtl/sc_tx_dpath.sv
module sc_tx_dpath
  import sc_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       errClr,
  input  logic       ioIn,
  input  txCtl_t     ctl,
  output logic       tdre,
  output logic       tend,
  output logic       ers,
  output logic       errSeen,
  output logic       ioOut
);
  logic [7:0] holdReg, frameReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      frameReg <= '0;
      tdre     <= 1'b1;
      tend     <= 1'b1;
      ers      <= 1'b0;
      errSeen  <= 1'b0;
    end else begin
      if (wrEn) holdReg <= wrData;
      if (ctl.load) frameReg <= holdReg;

      if (wrEn)          tdre <= 1'b0;
      else if (ctl.load) tdre <= 1'b1;

      if (wrEn)                  tend <= 1'b0;
      else if (ctl.done && tdre) tend <= 1'b1;

      if (ctl.sample && !ioIn) ers <= 1'b1;
      else if (errClr)         ers <= 1'b0;

      if (ctl.load)        errSeen <= 1'b0;
      else if (ctl.sample) errSeen <= !ioIn;
    end
  end

  always_comb begin
    ioOut = 1'b1;
    if (ctl.active) begin
      if (ctl.bitSel == 4'd0)       ioOut = 1'b0;
      else if (ctl.bitSel <= 4'd8)  ioOut = frameReg[3'(ctl.bitSel - 4'd1)];
      else if (ctl.bitSel == 4'd9)  ioOut = ^frameReg;
    end
  end

  // R2: data-empty only drops because the host wrote
  a_r2_tdre_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tdre) |-> $past(wrEn));

  // R4: error flag only rises from a low line at the sample point
  a_r4_ers_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ers) |-> $past(ctl.sample && !ioIn));

  // R6: transmit-end never follows a rejected character
  a_r6_tend_clean: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tend) |-> $past(!errSeen));
endmodule

// File: rtl/sc_t0_tx.sv
module sc_t0_tx
  import sc_tx_pkg::*;
#(
  parameter int ETU   = 372,
  parameter int LIM_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  input  logic             errClr,
  input  logic             rieEn,
  input  logic             tieEn,
  input  logic [LIM_W-1:0] retryLimit,
  input  logic             ioIn,
  output logic             ioOut,
  output logic             tdre,
  output logic             tend,
  output logic             ers,
  output logic             errIrq,
  output logic             endIrq
);
  txCtl_t ctl;
  logic   errSeen;

  sc_tx_ctrl #(.ETU(ETU), .LIM_W(LIM_W)) uCtrl (
    .clk(clk), .rstN(rstN), .holdFull(!tdre), .errSeen(errSeen),
    .retryLimit(retryLimit), .ctl(ctl)
  );

  sc_tx_dpath uDpath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .errClr(errClr),
    .ioIn(ioIn), .ctl(ctl), .tdre(tdre), .tend(tend), .ers(ers),
    .errSeen(errSeen), .ioOut(ioOut)
  );

  assign errIrq = ers & rieEn;
  assign endIrq = tend & tieEn;
endmodule

// File: tb/tb_sc_t0_tx.sv
module tb_sc_t0_tx;
  localparam int ETU  = 16;
  localparam int HALF = ETU / 2;
  localparam int NV   = 7;

  logic clk = 0, rstN = 0, wrEn = 0, errClr = 0, rieEn = 0, tieEn = 0, ioIn = 1;
  logic [7:0] wrData = 0;
  logic [3:0] retryLimit = 0;
  logic ioOut, tdre, tend, ers, errIrq, endIrq;
  int total = 0, bad = 0, cyc = 0;

  sc_t0_tx #(.ETU(ETU), .LIM_W(4)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .errClr(errClr),
    .rieEn(rieEn), .tieEn(tieEn), .retryLimit(retryLimit), .ioIn(ioIn),
    .ioOut(ioOut), .tdre(tdre), .tend(tend), .ers(ers),
    .errIrq(errIrq), .endIrq(endIrq)
  );

  always #5 clk = ~clk;

  // {data, errors to inject, limit, expect stop}
  localparam logic [19:0] VEC [NV] = '{
    {8'hA5, 4'd0, 4'd0, 4'd0},
    {8'h3C, 4'd1, 4'd0, 4'd0},
    {8'hFF, 4'd2, 4'd3, 4'd0},
    {8'h00, 4'd0, 4'd1, 4'd0},
    {8'h81, 4'd3, 4'd2, 4'd1},
    {8'h7E, 4'd1, 4'd1, 4'd0},
    {8'h01, 4'd2, 4'd1, 4'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] d, input bit idle);
    @(negedge clk); wrEn = 1; wrData = d;
    @(negedge clk); wrEn = 0;
    chk(tdre == 0, "R2 tdre cleared", tdre, 0);
    chk(tend == 0, "R2 tend cleared", tend, 0);
    if (idle) begin
      @(negedge clk);
      chk(tdre == 1, "R2 tdre set on load", tdre, 1);
      chk(ioOut == 0, "R2 start bit follows load", ioOut, 0);
    end
  endtask

  task automatic pulseClr();
    @(negedge clk); errClr = 1;
    @(negedge clk); errClr = 0;
    chk(ers == 0, "R4 errClr clears ers", ers, 0);
  endtask

  // current negedge is slot m0; when m0 == 0 wait for the start bit
  task automatic capture(input logic [7:0] d, input bit inject, input int m0);
    logic [10:0] got = '0, exp;
    exp = {1'b1, ^d, d, 1'b0};
    if (m0 == 0) while (ioOut !== 1'b0) @(negedge clk);
    for (int m = m0 + 1; m <= 11 * ETU + 2; m++) begin
      @(negedge clk);
      if (m == 10 * ETU) ioIn = inject ? 1'b0 : 1'b1;
      if (m == 11 * ETU) ioIn = 1'b1;
      if ((m % ETU) == HALF && (m / ETU) <= 10) got[m / ETU] = ioOut;
    end
    chk(got == exp, "R3 frame bits", got, exp);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc == 150000) begin
        bad++; total++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(ioOut == 1, "R1 line high", ioOut, 1);
    chk(tdre == 1, "R1 tdre", tdre, 1);
    chk(tend == 1, "R1 tend", tend, 1);
    chk(ers == 0, "R1 ers", ers, 0);
    chk(errIrq == 0 && endIrq == 0, "R1 irqs", {errIrq, endIrq}, 0);

    rieEn = 1; tieEn = 1;
    for (int v = 0; v < NV; v++) begin
      logic [7:0] d;
      int nErr, frames;
      bit stop;
      d = VEC[v][19:12];
      nErr = int'(VEC[v][11:8]);
      retryLimit = VEC[v][7:4];
      stop = VEC[v][0];
      frames = stop ? nErr : nErr + 1;
      doWrite(d, 1);
      for (int k = 0; k < frames; k++) begin
        bit inj;
        inj = (k < nErr);
        capture(d, inj, 0);
        if (inj) begin
          chk(ers == 1, "R4 error sampled", ers, 1);
          chk(errIrq == 1, "R5 error irq", errIrq, 1);
          chk(tend == 0, "R6 no tend on error", tend, 0);
          if (k != frames - 1) pulseClr();
        end else begin
          chk(tend == 1, "R7 tend on clean", tend, 1);
          chk(ers == 0, "R7 ers untouched", ers, 0);
          chk(endIrq == 1, "R7 end irq", endIrq, 1);
        end
      end
      if (stop) begin
        bit quiet = 1;
        for (int i = 0; i < 20 * ETU; i++) begin
          @(negedge clk);
          if (ioOut !== 1'b1) quiet = 0;
        end
        chk(quiet, "R8 line idle after limit", quiet, 1);
        chk(tend == 0, "R8 tend held low", tend, 0);
        chk(ers == 1, "R8 ers held", ers, 1);
        pulseClr();
      end
    end

    // R5/R7 masking of interrupts
    rieEn = 0; tieEn = 0; retryLimit = 0;
    doWrite(8'h5A, 1);
    capture(8'h5A, 1, 0);
    chk(ers == 1 && errIrq == 0, "R5 error irq masked", errIrq, 0);
    pulseClr();
    capture(8'h5A, 0, 0);
    chk(tend == 1 && endIrq == 0, "R7 end irq masked", endIrq, 0);

    // R9 byte queued during a frame
    tieEn = 1;
    doWrite(8'hC3, 1);
    @(negedge clk); wrEn = 1; wrData = 8'h96;
    @(negedge clk); wrEn = 0;
    chk(tdre == 0, "R9 holding full while sending", tdre, 0);
    capture(8'hC3, 0, 2);
    chk(tend == 0, "R9 tend withheld with byte queued", tend, 0);
    chk(tdre == 1, "R9 queued byte loaded", tdre, 1);
    capture(8'h96, 0, 0);
    chk(tend == 1, "R9 tend after queued byte", tend, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule